// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Line Takeover

This block turns per-channel interrupt events from a bank of timer channels into activity on a bank of interrupt lines or into a memory-write message request. Each channel presents one-cycle assert and deassert events along with its configuration. The configuration covers interrupt enable, level or edge signalling, message delivery enable, a route field naming the target line, and a message address and data word. A global enable gates delivery for every channel. A legacy mode bit moves channels 0 and 1 onto two fixed lines. Two external legacy interrupt inputs, one from an interval timer and one from a real-time clock, drive those same two lines while legacy mode is off.

Every output comes from a register, so each output reacts one clock after the input that caused it. Lines that several sources target at once carry the OR of those sources. The block does not perform the message write. It only presents an address and data pair with a one-cycle valid strobe, for a separate bus-master engine to carry out.

Top module: `irq_route_legacy`

## Requirements
- R1: After reset all lines are low, no message is valid, every status bit is 0 and `legacy_tmr_en` is 1.
- R2: While `legacy_mode` is 1, events of channel 0 target line 0 and events of channel 1 target line 8, and their route fields are ignored.
- R3: Channels 2 and above always target the line numbered by their route field. Channels 0 and 1 do the same while `legacy_mode` is 0.
- R4: An assert event is delivered only when the channel's `ch_int_en` and `glb_enable` are both 1. An undelivered assert on a channel without message delivery lowers that channel's held line.
- R5: A delivered assert with `ch_msg_en` set raises `msg_valid` for exactly one cycle, with that channel's address and data, and drives no line. When several channels do this in the same cycle, the lowest-numbered one is sent.
- R6: A delivered level-mode assert (`ch_level`=1) raises the target line one cycle later and holds it. A delivered edge-mode assert gives a one-cycle pulse and drops any line that the channel holds.
- R7: A deassert event lowers the channel's held line unless `ch_msg_en` is 1. With `ch_msg_en` set, the deassert leaves the line unchanged.
- R8: A channel's status bit follows `ch_level` on every assert event, whatever the enables. It clears on a deassert event. When assert and deassert arrive in the same cycle, the assert wins.
- R9: When `legacy_mode` turns on, every held line 0 or 8 is dropped and `legacy_tmr_en` goes to 0.
- R10: When `legacy_mode` is off, line 0 carries `ext_tmr_irq` and line 8 carries `ext_rtc_irq`, each delayed by one cycle, and `legacy_tmr_en` is 1. When legacy mode turns off, held lines 0 and 8 are dropped, and line 8 at once shows the last sampled clock input level.
- R11: A line driven by several sources in the same cycle is the OR of them. Lowering one source leaves the line high while another source still drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_enable | input | 1 | Global interrupt delivery enable |
| legacy_mode | input | 1 | Legacy line takeover mode |
| ch_assert | input | NUM_CH | Per-channel assert event, one cycle |
| ch_deassert | input | NUM_CH | Per-channel deassert event, one cycle |
| ch_int_en | input | NUM_CH | Per-channel interrupt enable |
| ch_level | input | NUM_CH | 1 = level signalling, 0 = edge |
| ch_msg_en | input | NUM_CH | Per-channel message delivery enable |
| ch_route | input | NUM_CH*ROUTE_W | Per-channel target line number, channel n at bits n*ROUTE_W upward |
| ch_msg_addr | input | NUM_CH*ADDR_W | Per-channel message address |
| ch_msg_data | input | NUM_CH*DATA_W | Per-channel message data |
| ext_tmr_irq | input | 1 | External interval-timer interrupt level |
| ext_rtc_irq | input | 1 | External real-time-clock interrupt level |
| irq_lines | output | NUM_LINES | Interrupt line bank |
| legacy_tmr_en | output | 1 | 1 while legacy mode is off |
| ch_status | output | NUM_CH | Per-channel level-interrupt status |
| msg_valid | output | 1 | Message request strobe |
| msg_addr | output | ADDR_W | Message address |
| msg_data | output | DATA_W | Message data |

## Verification
The hardest cases to reach are the legacy mode transitions that happen while channels still hold lines 0 or 8. In the same cases a channel of index 2 or above is routed onto a legacy line, or the clock input changed while legacy mode was on. Directed phases build these states on purpose before they flip the mode. A long random phase then narrows the route fields to lines 0, 3, 5 and 8, so that collisions, same-cycle assert and deassert, and mode flips under load happen often. A behavioural model in the bench is compared against the design on every cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   // Fixed lines taken over by channels 0 and 1 in legacy mode.
   parameter int unsigned IRQ_LEG_TMR_LINE = 0;
   parameter int unsigned IRQ_LEG_RTC_LINE = 8;

   // Per-cycle outcome of a channel's events.
   typedef enum logic [2:0] {
      DLV_NONE  = 3'd0,
      DLV_LEVEL = 3'd1,
      DLV_EDGE  = 3'd2,
      DLV_MSG   = 3'd3,
      DLV_DROP  = 3'd4
   } dlv_kind_e;

endpackage

// File: rtl/irq_chan_ctl.sv
module irq_chan_ctl
   import irq_route_pkg::*;
#(
   parameter int unsigned IDX     = 0,
   parameter int unsigned ROUTE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_assert,
   input  logic               ev_deassert,
   input  logic               int_en,
   input  logic               glb_en,
   input  logic               level_mode,
   input  logic               msg_en,
   input  logic [ROUTE_W-1:0] route,
   input  logic               legacy,
   input  logic               mode_chg,
   output logic               hold_q,
   output logic [ROUTE_W-1:0] hold_line_q,
   output logic               pulse_q,
   output logic [ROUTE_W-1:0] pulse_line_q,
   output logic               status_q,
   output logic               msg_req
);

   localparam logic [ROUTE_W-1:0] LINE_A = ROUTE_W'(IRQ_LEG_TMR_LINE);
   localparam logic [ROUTE_W-1:0] LINE_B = ROUTE_W'(IRQ_LEG_RTC_LINE);

   logic [ROUTE_W-1:0] eff_line;
   logic               deliver;
   logic               on_leg_line;
   dlv_kind_e          kind;

   // Channels 0 and 1 are the only ones legacy mode can redirect.
   generate
      if (IDX == 0) begin : g_leg_a
         assign eff_line = legacy ? LINE_A : route;
      end else if (IDX == 1) begin : g_leg_b
         assign eff_line = legacy ? LINE_B : route;
      end else begin : g_plain
         assign eff_line = route;
      end
   endgenerate

   assign deliver     = int_en & glb_en;
   assign on_leg_line = (hold_line_q == LINE_A) || (hold_line_q == LINE_B);

   always_comb begin
      kind = DLV_NONE;
      if (ev_assert) begin
         if (!deliver)        kind = msg_en ? DLV_NONE : DLV_DROP;
         else if (msg_en)     kind = DLV_MSG;
         else if (level_mode) kind = DLV_LEVEL;
         else                 kind = DLV_EDGE;
      end else if (ev_deassert && !msg_en) begin
         kind = DLV_DROP;
      end
   end

   assign msg_req = (kind == DLV_MSG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q       <= 1'b0;
         hold_line_q  <= '0;
         pulse_q      <= 1'b0;
         pulse_line_q <= '0;
         status_q     <= 1'b0;
      end else begin
         pulse_q <= (kind == DLV_EDGE);
         if (kind == DLV_EDGE) pulse_line_q <= eff_line;
         case (kind)
            DLV_LEVEL: begin
               hold_q      <= 1'b1;
               hold_line_q <= eff_line;
            end
            DLV_EDGE, DLV_DROP: hold_q <= 1'b0;
            default: if (mode_chg && on_leg_line) hold_q <= 1'b0;
         endcase
         if (ev_assert)        status_q <= level_mode;
         else if (ev_deassert) status_q <= 1'b0;
      end
   end

   // R6
   hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_q) |-> $past(ev_assert && level_mode && int_en && glb_en && !msg_en));

   // R6
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> (!pulse_q || $past(ev_assert)));

   // R8
   status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q) |-> $past(ev_assert && level_mode));

   // R7
   msg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_deassert && !ev_assert && msg_en && !mode_chg) |=> (hold_q == $past(hold_q)));

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned ROUTE_W   = 5
) (
   input  logic [NUM_CH-1:0]         hold,
   input  logic [NUM_CH*ROUTE_W-1:0] hold_line,
   input  logic [NUM_CH-1:0]         pulse,
   input  logic [NUM_CH*ROUTE_W-1:0] pulse_line,
   input  logic                      leg_q,
   input  logic                      tmr_q,
   input  logic                      rtc_q,
   output logic [NUM_LINES-1:0]      lines
);

   logic [NUM_CH-1:0][NUM_LINES-1:0] ch_vec;

   // One-hot contribution of each channel, then an OR reduction per line.
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         always_comb begin
            ch_vec[c] = '0;
            if (hold[c])  ch_vec[c][hold_line[c*ROUTE_W +: ROUTE_W]]  = 1'b1;
            if (pulse[c]) ch_vec[c][pulse_line[c*ROUTE_W +: ROUTE_W]] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      lines = '0;
      for (int c = 0; c < NUM_CH; c++) lines = lines | ch_vec[c];
      if (!leg_q) begin
         lines[IRQ_LEG_TMR_LINE] = lines[IRQ_LEG_TMR_LINE] | tmr_q;
         lines[IRQ_LEG_RTC_LINE] = lines[IRQ_LEG_RTC_LINE] | rtc_q;
      end
   end

endmodule

// File: rtl/irq_msg_sel.sv
module irq_msg_sel #(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter bit          HAS_MSG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        req,
   input  logic [NUM_CH*ADDR_W-1:0] addr_in,
   input  logic [NUM_CH*DATA_W-1:0] data_in,
   output logic                     msg_valid,
   output logic [ADDR_W-1:0]        msg_addr,
   output logic [DATA_W-1:0]        msg_data
);

   generate
      if (HAS_MSG) begin : g_msg
         logic [ADDR_W-1:0] pick_addr;
         logic [DATA_W-1:0] pick_data;

         // Lowest requesting channel wins: scan downward, last hit kept.
         always_comb begin
            pick_addr = '0;
            pick_data = '0;
            for (int i = NUM_CH - 1; i >= 0; i--) begin
               if (req[i]) begin
                  pick_addr = addr_in[i*ADDR_W +: ADDR_W];
                  pick_data = data_in[i*DATA_W +: DATA_W];
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               msg_valid <= 1'b0;
               msg_addr  <= '0;
               msg_data  <= '0;
            end else begin
               msg_valid <= |req;
               if (|req) begin
                  msg_addr <= pick_addr;
                  msg_data <= pick_data;
               end
            end
         end
      end else begin : g_no_msg
         assign msg_valid = 1'b0;
         assign msg_addr  = '0;
         assign msg_data  = '0;
      end
   endgenerate

endmodule

// File: rtl/irq_route_legacy.sv
module irq_route_legacy
   import irq_route_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          HAS_MSG   = 1'b1,
   localparam int unsigned ROUTE_W  = $clog2(NUM_LINES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      glb_enable,
   input  logic                      legacy_mode,
   input  logic [NUM_CH-1:0]         ch_assert,
   input  logic [NUM_CH-1:0]         ch_deassert,
   input  logic [NUM_CH-1:0]         ch_int_en,
   input  logic [NUM_CH-1:0]         ch_level,
   input  logic [NUM_CH-1:0]         ch_msg_en,
   input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
   input  logic [NUM_CH*ADDR_W-1:0]  ch_msg_addr,
   input  logic [NUM_CH*DATA_W-1:0]  ch_msg_data,
   input  logic                      ext_tmr_irq,
   input  logic                      ext_rtc_irq,
   output logic [NUM_LINES-1:0]      irq_lines,
   output logic                      legacy_tmr_en,
   output logic [NUM_CH-1:0]         ch_status,
   output logic                      msg_valid,
   output logic [ADDR_W-1:0]         msg_addr,
   output logic [DATA_W-1:0]         msg_data
);

   generate
      if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_ch
         $error("irq_route_legacy: NUM_CH must be 2..32");
      end
      if (NUM_LINES <= IRQ_LEG_RTC_LINE || (1 << ROUTE_W) != NUM_LINES) begin : g_bad_lines
         $error("irq_route_legacy: NUM_LINES must be a power of two above the legacy lines");
      end
   endgenerate

   logic                      leg_q, tmr_q, rtc_q;
   logic                      mode_chg;
   logic [NUM_CH-1:0]         hold, pulse, msg_req;
   logic [NUM_CH*ROUTE_W-1:0] hold_line, pulse_line;

   assign mode_chg      = legacy_mode ^ leg_q;
   assign legacy_tmr_en = ~leg_q;

   // External levels are always sampled; the clock input's level survives legacy mode.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         leg_q <= 1'b0;
         tmr_q <= 1'b0;
         rtc_q <= 1'b0;
      end else begin
         leg_q <= legacy_mode;
         tmr_q <= ext_tmr_irq;
         rtc_q <= ext_rtc_irq;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         irq_chan_ctl #(.IDX(c), .ROUTE_W(ROUTE_W)) i_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .ev_assert    (ch_assert[c]),
            .ev_deassert  (ch_deassert[c]),
            .int_en       (ch_int_en[c]),
            .glb_en       (glb_enable),
            .level_mode   (ch_level[c]),
            .msg_en       (ch_msg_en[c]),
            .route        (ch_route[c*ROUTE_W +: ROUTE_W]),
            .legacy       (legacy_mode),
            .mode_chg     (mode_chg),
            .hold_q       (hold[c]),
            .hold_line_q  (hold_line[c*ROUTE_W +: ROUTE_W]),
            .pulse_q      (pulse[c]),
            .pulse_line_q (pulse_line[c*ROUTE_W +: ROUTE_W]),
            .status_q     (ch_status[c]),
            .msg_req      (msg_req[c])
         );
      end
   endgenerate

   irq_line_merge #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W)) i_merge (
      .hold       (hold),
      .hold_line  (hold_line),
      .pulse      (pulse),
      .pulse_line (pulse_line),
      .leg_q      (leg_q),
      .tmr_q      (tmr_q),
      .rtc_q      (rtc_q),
      .lines      (irq_lines)
   );

   irq_msg_sel #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_MSG(HAS_MSG)) i_msg (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (msg_req),
      .addr_in   (ch_msg_addr),
      .data_in   (ch_msg_data),
      .msg_valid (msg_valid),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data)
   );

   // R9
   leg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(legacy_tmr_en == 1'b0) && $past(ch_assert == '0))
         |-> (!irq_lines[IRQ_LEG_TMR_LINE] && !irq_lines[IRQ_LEG_RTC_LINE]));

   // R5
   msg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $past(glb_enable && |(ch_assert & ch_int_en & ch_msg_en)));

   // R10
   rtc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_mode && $past(!legacy_mode) && ext_rtc_irq) |=> irq_lines[IRQ_LEG_RTC_LINE]);

endmodule

// File: tb/test_irq_route_legacy.sv
module test_irq_route_legacy;

   localparam int NCH = 4;
   localparam int NL  = 32;
   localparam int RW  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic glb_enable = 1'b0, legacy_mode = 1'b0;
   logic [NCH-1:0] ch_assert = '0, ch_deassert = '0, ch_int_en = '0, ch_level = '0, ch_msg_en = '0;
   logic [NCH*RW-1:0] ch_route = '0;
   logic [NCH*32-1:0] ch_msg_addr = '0, ch_msg_data = '0;
   logic ext_tmr_irq = 1'b0, ext_rtc_irq = 1'b0;
   logic [NL-1:0] irq_lines;
   logic legacy_tmr_en, msg_valid;
   logic [NCH-1:0] ch_status;
   logic [31:0] msg_addr, msg_data;

   always #5 clk = ~clk;

   irq_route_legacy #(.NUM_CH(NCH), .NUM_LINES(NL)) i_irq_route_legacy (
      .clk(clk), .rst_n(rst_n), .glb_enable(glb_enable), .legacy_mode(legacy_mode),
      .ch_assert(ch_assert), .ch_deassert(ch_deassert), .ch_int_en(ch_int_en),
      .ch_level(ch_level), .ch_msg_en(ch_msg_en), .ch_route(ch_route),
      .ch_msg_addr(ch_msg_addr), .ch_msg_data(ch_msg_data),
      .ext_tmr_irq(ext_tmr_irq), .ext_rtc_irq(ext_rtc_irq), .irq_lines(irq_lines),
      .legacy_tmr_en(legacy_tmr_en), .ch_status(ch_status), .msg_valid(msg_valid),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   string cur_req = "R1";
   bit finished = 0;

   // Behavioural reference state
   bit  m_hold [NCH];
   int  m_hline[NCH];
   bit  m_pulse[NCH];
   int  m_pline[NCH];
   bit  m_stat [NCH];
   bit  m_leg, m_tmr, m_rtc, m_mv;
   logic [31:0] m_ma, m_md;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_hold[c] = 0; m_hline[c] = 0; m_pulse[c] = 0; m_pline[c] = 0; m_stat[c] = 0;
         end
         m_leg = 0; m_tmr = 0; m_rtc = 0; m_mv = 0; m_ma = 0; m_md = 0;
      end else begin
         bit chg;
         bit any_msg;
         chg = (legacy_mode != m_leg);
         any_msg = 0;
         for (int c = 0; c < NCH; c++) begin
            int tgt;
            bit dlv;
            tgt = ch_route[c*RW +: RW];
            if (legacy_mode && c == 0) tgt = 0;
            if (legacy_mode && c == 1) tgt = 8;
            dlv = ch_int_en[c] && glb_enable;
            m_pulse[c] = 0;
            if (chg && (m_hline[c] == 0 || m_hline[c] == 8)) m_hold[c] = 0;
            if (ch_assert[c]) begin
               if (dlv && ch_msg_en[c]) begin
                  if (!any_msg) begin
                     any_msg = 1;
                     m_ma = ch_msg_addr[c*32 +: 32];
                     m_md = ch_msg_data[c*32 +: 32];
                  end
               end else if (dlv && ch_level[c]) begin
                  m_hold[c] = 1; m_hline[c] = tgt;
               end else if (dlv) begin
                  m_hold[c] = 0; m_pulse[c] = 1; m_pline[c] = tgt;
               end else if (!ch_msg_en[c]) begin
                  m_hold[c] = 0;
               end
               m_stat[c] = ch_level[c];
            end else if (ch_deassert[c]) begin
               if (!ch_msg_en[c]) m_hold[c] = 0;
               m_stat[c] = 0;
            end
         end
         m_mv = any_msg;
         m_leg = legacy_mode; m_tmr = ext_tmr_irq; m_rtc = ext_rtc_irq;
      end
   end

   function automatic logic [NL-1:0] exp_lines();
      logic [NL-1:0] v = '0;
      for (int c = 0; c < NCH; c++) begin
         if (m_hold[c])  v[m_hline[c]] = 1'b1;
         if (m_pulse[c]) v[m_pline[c]] = 1'b1;
      end
      if (!m_leg) begin
         v[0] = v[0] | m_tmr;
         v[8] = v[8] | m_rtc;
      end
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare against the model on every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [NCH-1:0] es;
         for (int c = 0; c < NCH; c++) es[c] = m_stat[c];
         chk(irq_lines === exp_lines(), cur_req, "irq_lines", 64'(irq_lines), 64'(exp_lines()));
         chk(legacy_tmr_en === !m_leg, cur_req, "legacy_tmr_en", 64'(legacy_tmr_en), 64'(!m_leg));
         chk(ch_status === es, cur_req, "ch_status", 64'(ch_status), 64'(es));
         chk(msg_valid === m_mv, cur_req, "msg_valid", 64'(msg_valid), 64'(m_mv));
         if (m_mv) begin
            chk(msg_addr === m_ma, cur_req, "msg_addr", 64'(msg_addr), 64'(m_ma));
            chk(msg_data === m_md, cur_req, "msg_data", 64'(msg_data), 64'(m_md));
         end
      end
   end

   task automatic cfg(input int c, input bit en, input bit lvl, input bit msg, input int rt);
      ch_int_en[c] = en; ch_level[c] = lvl; ch_msg_en[c] = msg;
      ch_route[c*RW +: RW] = RW'(rt);
      ch_msg_addr[c*32 +: 32] = 32'hA000_0000 + 32'(c);
      ch_msg_data[c*32 +: 32] = 32'h5000_0000 + 32'(c * 17);
   endtask

   task automatic fire(input logic [NCH-1:0] a, input logic [NCH-1:0] d);
      @(negedge clk);
      ch_assert = a; ch_deassert = d;
      @(negedge clk);
      ch_assert = '0; ch_deassert = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk(irq_lines === '0, "R1", "reset lines", 64'(irq_lines), 0);
      chk(legacy_tmr_en === 1'b1, "R1", "reset legacy_tmr_en", 64'(legacy_tmr_en), 1);
      chk(msg_valid === 1'b0, "R1", "reset msg_valid", 64'(msg_valid), 0);
      glb_enable = 1'b1;

      // Route field use with legacy off
      cur_req = "R3";
      cfg(2, 1, 1, 0, 5); cfg(0, 1, 1, 0, 3);
      fire(4'b0101, 4'b0000);
      chk(irq_lines[5] && irq_lines[3], "R3", "routed lines", 64'(irq_lines), 64'h28);
      idle(2);

      // Level hold and deassert
      cur_req = "R7";
      fire(4'b0000, 4'b0100);
      chk(!irq_lines[5], "R7", "line 5 after deassert", 64'(irq_lines[5]), 0);
      cur_req = "R6";
      cfg(3, 1, 0, 0, 12);
      fire(4'b1000, 4'b0000);
      chk(irq_lines[12], "R6", "edge pulse on line 12", 64'(irq_lines[12]), 1);
      idle(1);
      chk(!irq_lines[12], "R6", "pulse ended", 64'(irq_lines[12]), 0);

      // Legacy on: ch0 held on line 3 keeps it; channels redirected
      cur_req = "R9";
      cfg(2, 1, 1, 0, 8);
      fire(4'b0100, 4'b0000);
      @(negedge clk); legacy_mode = 1'b1;
      @(negedge clk);
      chk(!irq_lines[8] && !legacy_tmr_en, "R9", "line 8 dropped, tmr_en low",
          64'({irq_lines[8], legacy_tmr_en}), 0);
      cur_req = "R2";
      cfg(0, 1, 1, 0, 20); cfg(1, 1, 0, 0, 21);
      fire(4'b0011, 4'b0000);
      chk(irq_lines[0] && irq_lines[8] && !irq_lines[20] && !irq_lines[21], "R2",
          "legacy redirect", 64'(irq_lines), 64'h101);
      idle(2);

      // External inputs gated in legacy mode, rtc level remembered
      cur_req = "R10";
      ext_rtc_irq = 1'b1; ext_tmr_irq = 1'b1;
      idle(2);
      @(negedge clk); legacy_mode = 1'b0;
      @(negedge clk);
      chk(irq_lines[8] && legacy_tmr_en, "R10", "rtc level on leaving legacy",
          64'({irq_lines[8], legacy_tmr_en}), 3);
      ext_tmr_irq = 1'b0; ext_rtc_irq = 1'b0;
      idle(2);

      // Enables gate delivery, status still updated
      cur_req = "R4";
      cfg(2, 0, 1, 0, 9);
      fire(4'b0100, 4'b0000);
      chk(!irq_lines[9] && ch_status[2], "R4", "disabled assert", 64'({irq_lines[9], ch_status[2]}), 1);
      cur_req = "R8";
      fire(4'b0100, 4'b0100);
      chk(ch_status[2], "R8", "assert wins over deassert", 64'(ch_status[2]), 1);
      fire(4'b0000, 4'b0100);
      chk(!ch_status[2], "R8", "status cleared", 64'(ch_status[2]), 0);

      // Messages, lowest index wins, no line
      cur_req = "R5";
      cfg(1, 1, 1, 1, 6); cfg(3, 1, 1, 1, 7);
      fire(4'b1010, 4'b0000);
      chk(msg_valid && msg_addr == 32'hA000_0001 && !irq_lines[6], "R5", "message pick",
          64'(msg_addr), 64'hA000_0001);
      idle(1);
      chk(!msg_valid, "R5", "one cycle strobe", 64'(msg_valid), 0);

      // OR merge
      cur_req = "R11";
      cfg(2, 1, 1, 0, 7); cfg(3, 1, 1, 0, 7);
      fire(4'b1100, 4'b0000);
      fire(4'b0000, 4'b0100);
      chk(irq_lines[7], "R11", "line held by second source", 64'(irq_lines[7]), 1);
      fire(4'b0000, 4'b1000);
      idle(2);

      // Random mix with colliding routes
      cur_req = "R11";
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            int pick;
            pick = int'($urandom_range(0, 3));
            cfg(c, ($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
                $urandom_range(0, 5) == 0, (pick == 0) ? 0 : (pick == 1) ? 3 : (pick == 2) ? 5 : 8);
         end
         ch_assert   = NCH'($urandom) & NCH'($urandom);
         ch_deassert = NCH'($urandom) & NCH'($urandom);
         if ($urandom_range(0, 15) == 0) legacy_mode = ~legacy_mode;
         if ($urandom_range(0, 31) == 0) glb_enable = ~glb_enable;
         ext_tmr_irq = $urandom_range(0, 1) == 1;
         ext_rtc_irq = $urandom_range(0, 1) == 1;
      end
      @(negedge clk);
      ch_assert = '0; ch_deassert = '0;
      idle(3);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule